// File: doc/BRIEF.md
# Implicit-Length Packed String Comparator

This unit compares two 128-bit operands that each hold a short string ended by a zero element. A control byte says whether the operands are read as sixteen 8-bit elements or eight 16-bit elements, and whether those elements are signed. It also picks one of four ways of combining the element comparisons into a 16-bit match vector, and how that vector is inverted. The length of each string is never given explicitly. It follows from where the lowest zero element sits.

A caller presents both operands and the control byte and raises `start` for one cycle. After the next clock edge the unit shows the match vector and two flags. The flags say whether each operand holds any zero element. `done` is high for that one cycle. The outputs then hold until the next start. Turning the match vector into an index or a mask is left to logic downstream.

Top module: `nullterm_strcmp`

## Requirements
- R1: `ctrl[0]` selects the element format. With 1 there are 8 word elements, and element i is bits 16i+15..16i. With 0 there are 16 byte elements, and element i is bits 8i+7..8i. `ctrl[1]` = 1 makes elements signed (two's complement). Signedness only affects the range mode.
- R2: An element is valid only if its index is below that of the lowest zero element of its operand. The zero element itself and every element above it are invalid.
- R3: `a_has_null` / `b_has_null` are 1 when any element of `op_a` / `op_b`, in the selected format, is zero.
- R4: With `ctrl[3:2]` = 00 (match any), bit j is set when `op_b` element j is valid and equals some valid `op_a` element.
- R5: With `ctrl[3:2]` = 01 (ranges), bit j is set when `op_b` element j is valid and there is a pair k with `op_a` elements 2k and 2k+1 both valid and a[2k] <= b[j] <= a[2k+1].
- R6: With `ctrl[3:2]` = 10 (element-wise equal), bit i is set when elements i of both operands are valid and equal, or when both are invalid.
- R7: With `ctrl[3:2]` = 11 (ordered substring), bit j is set when, for every k with j+k below the element count, either a[k] is invalid, or b[j+k] is valid and equals a[k].
- R8: `ctrl[5:4]` sets polarity. 00 and 10 pass the vector unchanged. 01 inverts all element bits. 11 inverts only bits j where `op_b` element j is valid. `ctrl[7:6]` have no effect.
- R9: In word format, `match_vec[15:8]` is zero.
- R10: Outputs update on the clock edge that samples `start` high. `done` is high in exactly the cycle after each sampled start. Without a start, all outputs hold.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request for the current operands and control |
| op_a | input | 128 | First operand (set / range / needle string) |
| op_b | input | 128 | Second operand (searched string) |
| ctrl | input | 8 | Format, aggregation mode and polarity |
| match_vec | output | 16 | Aggregated, polarity-adjusted match vector |
| a_has_null | output | 1 | `op_a` contains a zero element |
| b_has_null | output | 1 | `op_b` contains a zero element |
| done | output | 1 | One-cycle pulse marking new results |

## Verification
The datapath is a single register stage, so any wrong result shows at the ports one cycle after the faulty start. Examples are a mis-derived validity mask, a wrong comparison or a misplaced inversion. The bench compares all outputs against a behavioural model on every clock. Validity faults show first in the cases that hinge on the terminator: equal-each past the end of both strings, needle tails in ordered search, and masked inversion. Operands with zeros at random positions exercise those cases. A hold fault shows as output drift in cycles without `start`.

// File: rtl/nullterm_strcmp.sv
module nullterm_strcmp (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] op_a,
  input  logic [127:0] op_b,
  input  logic [7:0]   ctrl,
  output logic [15:0]  match_vec,
  output logic         a_has_null,
  output logic         b_has_null,
  output logic         done
);
  logic word_m, sgn_m;
  logic [1:0] agg, pol;
  int lim;
  logic unused_ctrl;

  assign word_m = ctrl[0];
  assign sgn_m  = ctrl[1];
  assign agg    = ctrl[3:2];
  assign pol    = ctrl[5:4];
  assign lim    = word_m ? 8 : 16;
  assign unused_ctrl = ^ctrl[7:6];

  logic signed [16:0] ea [16];
  logic signed [16:0] eb [16];
  logic [15:0] va, vb, res1, res2;
  logic na, nb;

  always_comb begin : unpack
    for (int i = 0; i < 16; i++) begin
      ea[i] = sgn_m ? 17'($signed(op_a[8*i +: 8])) : {9'b0, op_a[8*i +: 8]};
      eb[i] = sgn_m ? 17'($signed(op_b[8*i +: 8])) : {9'b0, op_b[8*i +: 8]};
    end
    if (word_m) begin
      for (int i = 0; i < 8; i++) begin
        ea[i] = sgn_m ? 17'($signed(op_a[16*i +: 16])) : {1'b0, op_a[16*i +: 16]};
        eb[i] = sgn_m ? 17'($signed(op_b[16*i +: 16])) : {1'b0, op_b[16*i +: 16]};
      end
    end
  end

  always_comb begin : lengths
    logic sa, sb;
    sa = 1'b0;
    sb = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i < lim) begin
        if (ea[i] == '0) sa = 1'b1;
        if (eb[i] == '0) sb = 1'b1;
      end
      va[i] = (i < lim) && !sa;
      vb[i] = (i < lim) && !sb;
    end
    na = sa;
    nb = sb;
  end

  always_comb begin : aggregate
    res1 = '0;
    for (int j = 0; j < 16; j++) begin
      case (agg)
        2'b00:
          for (int i = 0; i < 16; i++)
            if (va[i] && vb[j] && ea[i] == eb[j]) res1[j] = 1'b1;
        2'b01:
          for (int i = 0; i < 16; i += 2)
            if (va[i] && va[i+1] && vb[j] && eb[j] >= ea[i] && eb[j] <= ea[i+1])
              res1[j] = 1'b1;
        2'b10:
          res1[j] = (j < lim) &&
                    ((va[j] && vb[j] && ea[j] == eb[j]) || (!va[j] && !vb[j]));
        default: begin
          res1[j] = (j < lim);
          for (int k = 0; k < 16 - j; k++)
            if (k < lim - j && va[k] && !(vb[j+k] && ea[k] == eb[j+k]))
              res1[j] = 1'b0;
        end
      endcase
    end
  end

  always_comb begin : polarity
    case (pol)
      2'b01:   res2 = ~res1;
      2'b11:   res2 = res1 ^ vb;
      default: res2 = res1;
    endcase
    if (word_m) res2[15:8] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_vec  <= '0;
      a_has_null <= 1'b0;
      b_has_null <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        match_vec  <= res2;
        a_has_null <= na;
        b_has_null <= nb;
      end
    end
  end
endmodule

// File: rtl/nullterm_strcmp_chk.sv
module nullterm_strcmp_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [127:0] op_a,
  input logic [127:0] op_b,
  input logic [7:0]   ctrl,
  input logic [15:0]  match_vec,
  input logic         a_has_null,
  input logic         b_has_null,
  input logic         done
);
  // R10
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(match_vec) && $stable(a_has_null) && $stable(b_has_null)));

  // R9
  word_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ctrl[0]) |=> match_vec[15:8] == 8'h00);

  // R3
  a_lead_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_a[15:0] == 16'h0000) |=> a_has_null);

  // R3
  b_lead_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_b[15:0] == 16'h0000) |=> b_has_null);

  // R4
  empty_b_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ctrl[3:2] == 2'b00 && ctrl[5:4] != 2'b01 && op_b[15:0] == 16'h0000)
      |=> match_vec == 16'h0000);
endmodule

bind nullterm_strcmp nullterm_strcmp_chk u_chk (.*);

// File: tb/nullterm_strcmp_tb.sv
module nullterm_strcmp_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [7:0] ctrl = '0;
  logic [15:0] match_vec;
  logic a_has_null, b_has_null, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] exp_match = '0;
  logic exp_na = 1'b0, exp_nb = 1'b0, exp_done = 1'b0;
  string exp_tag = "R11 reset";

  always #10 clk = ~clk;

  nullterm_strcmp u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b), .ctrl(ctrl),
    .match_vec(match_vec), .a_has_null(a_has_null), .b_has_null(b_has_null), .done(done)
  );

  function automatic int elem(logic [127:0] v, int i, bit wd, bit sg);
    logic [127:0] t;
    int x;
    if (wd) begin
      t = v >> (16 * i);
      x = int'(t[15:0]);
      if (sg && x > 32767) x -= 65536;
    end else begin
      t = v >> (8 * i);
      x = int'(t[7:0]);
      if (sg && x > 127) x -= 256;
    end
    return x;
  endfunction

  function automatic logic [15:0] model(logic [127:0] a, logic [127:0] b, logic [7:0] c,
                                        output bit na, output bit nb);
    int n, la, lb;
    int av[16], bv[16];
    logic [15:0] r;
    bit hit;
    n = c[0] ? 8 : 16;
    la = n;
    lb = n;
    for (int i = 0; i < 16; i++) begin
      av[i] = 0;
      bv[i] = 0;
    end
    for (int i = 0; i < n; i++) begin
      av[i] = elem(a, i, c[0], c[1]);
      bv[i] = elem(b, i, c[0], c[1]);
    end
    for (int i = n - 1; i >= 0; i--) begin
      if (av[i] == 0) la = i;
      if (bv[i] == 0) lb = i;
    end
    na = (la < n);
    nb = (lb < n);
    r = '0;
    for (int j = 0; j < n; j++) begin
      hit = 1'b0;
      case (c[3:2])
        2'b00: for (int i = 0; i < la; i++) if (j < lb && av[i] == bv[j]) hit = 1'b1;
        2'b01: for (int i = 0; i + 1 < la; i += 2)
                 if (j < lb && bv[j] >= av[i] && bv[j] <= av[i+1]) hit = 1'b1;
        2'b10: hit = (j < la && j < lb) ? (av[j] == bv[j]) : (j >= la && j >= lb);
        default: begin
          hit = 1'b1;
          for (int k = 0; k < la && j + k < n; k++)
            if (!(j + k < lb && av[k] == bv[j+k])) hit = 1'b0;
        end
      endcase
      r[j] = hit;
    end
    case (c[5:4])
      2'b01: for (int j = 0; j < n; j++) r[j] = ~r[j];
      2'b11: for (int j = 0; j < lb; j++) r[j] = ~r[j];
      default: ;
    endcase
    return r;
  endfunction

  function automatic string mode_tag(logic [7:0] c);
    string s;
    case (c[3:2])
      2'b00: s = "R4 match-any";
      2'b01: s = "R5 ranges";
      2'b10: s = "R6 element-wise";
      default: s = "R7 ordered";
    endcase
    return {s, " with R1 R2 R8 R9"};
  endfunction

  always @(posedge clk) begin
    bit tna, tnb;
    if (!rst_n) begin
      exp_match <= '0; exp_na <= 1'b0; exp_nb <= 1'b0; exp_done <= 1'b0;
      exp_tag <= "R11 reset";
    end else begin
      exp_done <= start;
      if (start) begin
        exp_match <= model(op_a, op_b, ctrl, tna, tnb);
        exp_na <= tna;
        exp_nb <= tnb;
        exp_tag <= mode_tag(ctrl);
      end
    end
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (!finished) begin
      chk(rst_n ? "R10 done pulse" : "R11 reset done", {15'b0, done}, {15'b0, exp_done});
      chk(rst_n ? "R3 a null flag" : "R11 reset flag", {15'b0, a_has_null}, {15'b0, exp_na});
      chk(rst_n ? "R3 b null flag" : "R11 reset flag", {15'b0, b_has_null}, {15'b0, exp_nb});
      chk(exp_tag, match_vec, exp_match);
    end
  end

  function automatic logic [127:0] str(string s);
    logic [127:0] v = '0;
    for (int i = 0; i < s.len() && i < 16; i++) v[8*i +: 8] = s[i];
    return v;
  endfunction

  function automatic logic [127:0] rnd_op(bit wd);
    logic [127:0] v = '0;
    int r, z;
    for (int i = 0; i < 16; i++) begin
      r = $urandom_range(0, 5);
      v[8*i +: 8] = (r < 5) ? 8'(8'h41 + r) : 8'($urandom);
    end
    if ($urandom_range(0, 3) != 0) begin
      z = $urandom_range(0, wd ? 7 : 15);
      if (wd) v = v & ~({112'b0, 16'hFFFF} << (16 * z));
      else    v = v & ~({120'b0, 8'hFF} << (8 * z));
    end
    return v;
  endfunction

  task automatic run(logic [127:0] a, logic [127:0] b, logic [7:0] c);
    @(negedge clk);
    op_a = a; op_b = b; ctrl = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs at zero during reset
    chk("R11 reset match", match_vec, 16'h0000);
    chk("R11 reset done", {15'b0, done}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: identical strings, tail positions both invalid count as equal
    run(str("hello"), str("hello"), 8'h08);
    chk("R6 equal strings", match_vec, 16'hFFFF);
    // R7: needle "lo" found at position 3 of "hello"
    run(str("lo"), str("hello"), 8'h0C);
    chk("R7 substring at 3", match_vec, 16'h0008);
    // R2: element after the terminator in op_a is ignored
    run(str("ab") | (128'h7A << 24), str("z"), 8'h00);
    chk("R2 past terminator", match_vec, 16'h0000);
    run(str("ab") | (128'h7A << 24), str("ab"), 8'h00);
    chk("R2 R4 inside length", match_vec, 16'h0003);
    // R1 R5: signed range [-16, 16] holds 5 and -8, not 32 or 127
    run({112'b0, 8'h10, 8'hF0}, {88'b0, 8'h7F, 8'h20, 8'hF8, 8'h05}, 8'h06);
    chk("R1 R5 signed range", match_vec, 16'h0003);
    run({112'b0, 8'h10, 8'hF0}, {88'b0, 8'h7F, 8'h20, 8'hF8, 8'h05}, 8'h04);
    chk("R1 R5 unsigned range empty", match_vec, 16'h0000);
    chk("R3 a null present", {15'b0, a_has_null}, 16'h0001);
    // R9: word format, both empty, element-wise gives only low 8 bits
    run('0, '0, 8'h09);
    chk("R9 word upper zero", match_vec, 16'h00FF);
    // R8: invert all on empty match-any, word format
    run(str("abcd"), '0, 8'h11);
    chk("R8 invert all word", match_vec, 16'h00FF);
    // R8: masked inversion only over valid op_b, ctrl[7:6] ignored
    run(str("x"), str("abc"), 8'hF0);
    chk("R8 masked invert", match_vec, 16'h0007);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] c;
      c = 8'($urandom);
      @(negedge clk);
      op_a = rnd_op(c[0]);
      op_b = ($urandom_range(0, 3) == 0) ? (op_a << (8 * $urandom_range(0, 4))) : rnd_op(c[0]);
      ctrl = c;
      start = ($urandom_range(0, 2) != 0);
    end
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule